// File: doc/BRIEF.md
# Cascaded Dual-CPU Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into three 32-bit cause words and drives one interrupt line to each of two processors. Sources 0 to 31 land in the low cause word and 32 to 63 in the high cause word. Sources 64 to 95 come from general-purpose pins and are held in a pin cause word. That pin word is masked and folded, eight pins per bit, into four summary bits of the high word. This builds a two-level cascade.

The first processor has a mask per main word and an identification port. When that port is pulsed, it returns the number of the source to service next, or a bogus code when no source qualifies. If the winner is a pin source, the controller also clears that pin's cause bit. The second processor sees only the doorbell source. Software reaches the cause words, the masks and an enable/disable command register through a single-cycle read/write bus. Writing a cause word clears each bit that is written as zero.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Interrupt numbers 0–31 are bits of the low cause word, 32–63 are bits of the high cause word, and 64–95 are bits 0–31 of the pin cause word. The identification port returns these numbers.
- R2: Before any selection, the low word is ANDed with 0x3dfffffe and the high word with 0x1f0003f7. A cause bit outside these constants never raises the CPU0 line and is never returned.
- R3: For CPU0, the masked and filtered low word is searched first. The high word is searched only when that low result is zero.
- R4: Within the word that is searched, the winner is the highest set bit.
- R5: When neither masked word has a set bit, the identification result is the bogus code 8'hFE (-2). A request pulsed in cycle N gives id_valid and id_num in cycle N+1.
- R6: High cause bits 24, 25, 26 and 27 are the OR of the masked pin cause bits 0–7, 8–15, 16–23 and 24–31 respectively. A pin cause bit whose mask bit is 0 adds nothing to them.
- R7: A winner on high bits 24–27 is resolved to 64 plus the highest set masked pin cause bit. At the same edge, that pin cause bit is cleared.
- R8: A write to a cause word clears each bit written as 0 and leaves each bit written as 1 unchanged. Cause addresses: 0 low, 1 high, 2 pin.
- R9: A cause bit is set by its source in any cycle with no clear. When the source is still high after a write-zero clear, the bit reads 0 in the cycle right after the write and 1 one cycle later.
- R10: cpu1_irq is low cause bit 28 ANDed with the CPU1 doorbell mask. The CPU1 mask is at address 6 and only bit 28 is stored there. An enable or disable command for number 28 changes the CPU1 mask and leaves the CPU0 low mask unchanged.
- R11: After reset, all cause words are 0. The CPU0 low mask (address 3), the pin mask (address 5) and the CPU1 mask (address 6) read 0. The CPU0 high mask (address 4) reads 0x0f000000.
- R12: cpu0_irq is high exactly when the filtered, masked low word or the filtered, masked high word has a set bit.
- R13: A write to address 7 is a command. Bits 6:0 give a number and bit 7 sets (1) or clears (0) that number's mask bit: 0–31 in the CPU0 low mask, 32–63 in the CPU0 high mask, 64–95 in the pin mask. Numbers of 96 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo | input | 32 | Level sources for interrupt numbers 0–31 |
| src_hi | input | 32 | Level sources for interrupt numbers 32–63 (bits 24–27 unused) |
| src_gpp | input | 32 | Level sources for pins, interrupt numbers 64–95 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| id_req | input | 1 | Identification request pulse for CPU0 |
| id_valid | output | 1 | Identification result valid, one cycle after id_req |
| id_num | output | 8 | Winning interrupt number or 8'hFE |
| cpu0_irq | output | 1 | Interrupt line to CPU0 |
| cpu1_irq | output | 1 | Doorbell interrupt line to CPU1 |

## Verification
The bench builds the block with its default parameters: 32-bit words, four summary groups of eight pins starting at high bit 24, doorbell at bit 28 and an 8-bit identifier. This places the filtered-out low bits 0 and 25, the summary window and the doorbell at the positions the requirements name. With this setting, a single request can resolve through the cascade to a number in the 64–95 range. It also lets the number-28 command be steered away from the CPU0 mask, and lets the clear-then-re-set sequence of a held source be observed cycle by cycle on the cause read path.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
   typedef enum logic [2:0] {
      RA_CAUSE_LO  = 3'd0,
      RA_CAUSE_HI  = 3'd1,
      RA_CAUSE_GPP = 3'd2,
      RA_MASK0_LO  = 3'd3,
      RA_MASK0_HI  = 3'd4,
      RA_MASK_GPP  = 3'd5,
      RA_MASK1_LO  = 3'd6,
      RA_IRQ_CMD   = 3'd7
   } reg_addr_e;

   localparam int unsigned ADDR_W     = 3;
   localparam int unsigned CMD_EN_BIT = 7;
   localparam int unsigned CMD_NUM_W  = 7;
endpackage

// File: rtl/cirq_cause_word.sv
module cirq_cause_word #(
   parameter int unsigned         W         = 32,
   parameter logic [W-1:0]        KEEP_MASK = {W{1'b1}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] ack_clr,
   output logic [W-1:0] q
);
   logic         clearing;
   logic [W-1:0] keep_vec;
   logic [W-1:0] q_next;

   always_comb begin
      clearing = wr_en | (|ack_clr);
      keep_vec = (wr_en ? wr_data : {W{1'b1}}) & ~ack_clr;
      if (clearing)
         q_next = q & keep_vec;
      else
         q_next = q | src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= q_next & KEEP_MASK;
   end
endmodule

// File: rtl/cirq_msb_find.sv
module cirq_msb_find #(
   parameter int unsigned W     = 32,
   parameter int unsigned IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i])
            idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/cirq_mask_bank.sv
module cirq_mask_bank
   import cirq_pkg::*;
#(
   parameter int unsigned  W            = 32,
   parameter int unsigned  DOORBELL_BIT = 28,
   parameter logic [W-1:0] M0HI_RESET   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      m0_lo,
   output logic [W-1:0]      m0_hi,
   output logic [W-1:0]      m_gpp,
   output logic              m1_db
);
   localparam int unsigned BIT_W = $clog2(W);

   logic [W-1:0]     lo_n, hi_n, gpp_n;
   logic             db_n;
   int unsigned      cmd_num;
   int unsigned      cmd_word;
   logic [BIT_W-1:0] cmd_bit;
   logic             cmd_en;

   always_comb begin
      lo_n     = m0_lo;
      hi_n     = m0_hi;
      gpp_n    = m_gpp;
      db_n     = m1_db;
      cmd_num  = 32'(wdata[CMD_NUM_W-1:0]);
      cmd_word = cmd_num / W;
      cmd_bit  = BIT_W'(cmd_num % W);
      cmd_en   = wdata[CMD_EN_BIT];
      if (wr_en) begin
         case (reg_addr_e'(addr))
            RA_MASK0_LO: lo_n  = wdata;
            RA_MASK0_HI: hi_n  = wdata;
            RA_MASK_GPP: gpp_n = wdata;
            RA_MASK1_LO: db_n  = wdata[DOORBELL_BIT];
            RA_IRQ_CMD: begin
               if (cmd_num == DOORBELL_BIT)
                  db_n = cmd_en;
               else if (cmd_word == 0)
                  lo_n[cmd_bit] = cmd_en;
               else if (cmd_word == 1)
                  hi_n[cmd_bit] = cmd_en;
               else if (cmd_word == 2)
                  gpp_n[cmd_bit] = cmd_en;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m0_lo <= '0;
         m0_hi <= M0HI_RESET;
         m_gpp <= '0;
         m1_db <= 1'b0;
      end else begin
         m0_lo <= lo_n;
         m0_hi <= hi_n;
         m_gpp <= gpp_n;
         m1_db <= db_n;
      end
   end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
   import cirq_pkg::*;
#(
   parameter int unsigned       WORD_W       = 32,
   parameter int unsigned       GPP_GROUPS   = 4,
   parameter int unsigned       CASCADE_LSB  = 24,
   parameter int unsigned       DOORBELL_BIT = 28,
   parameter int unsigned       ID_W         = 8,
   parameter logic [WORD_W-1:0] LO_VALID     = 32'h3dff_fffe,
   parameter logic [WORD_W-1:0] HI_VALID     = 32'h1f00_03f7,
   parameter logic [ID_W-1:0]   BOGUS_ID     = 8'hFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] src_lo,
   input  logic [WORD_W-1:0] src_hi,
   input  logic [WORD_W-1:0] src_gpp,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              id_req,
   output logic              id_valid,
   output logic [ID_W-1:0]   id_num,
   output logic              cpu0_irq,
   output logic              cpu1_irq
);
   localparam int unsigned       IDX_W    = $clog2(WORD_W);
   localparam int unsigned       GRP_W    = WORD_W / GPP_GROUPS;
   localparam logic [WORD_W-1:0] GRP_ONES = WORD_W'((64'd1 << GPP_GROUPS) - 64'd1);
   localparam logic [WORD_W-1:0] SUM_BITS = GRP_ONES << CASCADE_LSB;
   localparam logic [IDX_W-1:0]  CAS_LO   = IDX_W'(CASCADE_LSB);
   localparam logic [IDX_W-1:0]  CAS_HI   = IDX_W'(CASCADE_LSB + GPP_GROUPS - 1);
   localparam logic [ID_W-1:0]   HI_BASE  = ID_W'(WORD_W);
   localparam logic [ID_W-1:0]   GPP_BASE = ID_W'(2 * WORD_W);

   // elaboration-time parameter checks
   if (WORD_W % GPP_GROUPS != 0)
      $error("WORD_W must split evenly into GPP_GROUPS");
   if (CASCADE_LSB + GPP_GROUPS > WORD_W)
      $error("summary window exceeds the high word");
   if (DOORBELL_BIT >= WORD_W)
      $error("doorbell bit outside the low word");
   if (WORD_W <= CMD_EN_BIT)
      $error("word too narrow for the command format");
   if (3 * WORD_W > (1 << CMD_NUM_W))
      $error("command number field too narrow");
   if (int'(BOGUS_ID) < 3 * WORD_W)
      $error("bogus code collides with a valid number");

   // cause words
   logic [WORD_W-1:0] lo_q, hi_q, gpp_q;
   logic [WORD_W-1:0] ack_vec;
   logic              wr_lo, wr_hi, wr_gpp;

   assign wr_lo  = bus_wr && (bus_addr == RA_CAUSE_LO);
   assign wr_hi  = bus_wr && (bus_addr == RA_CAUSE_HI);
   assign wr_gpp = bus_wr && (bus_addr == RA_CAUSE_GPP);

   cirq_cause_word #(.W(WORD_W)) u_cause_lo (
      .clk(clk), .rst_n(rst_n), .src(src_lo), .wr_en(wr_lo),
      .wr_data(bus_wdata), .ack_clr('0), .q(lo_q));

   cirq_cause_word #(.W(WORD_W), .KEEP_MASK(~SUM_BITS)) u_cause_hi (
      .clk(clk), .rst_n(rst_n), .src(src_hi), .wr_en(wr_hi),
      .wr_data(bus_wdata), .ack_clr('0), .q(hi_q));

   cirq_cause_word #(.W(WORD_W)) u_cause_gpp (
      .clk(clk), .rst_n(rst_n), .src(src_gpp), .wr_en(wr_gpp),
      .wr_data(bus_wdata), .ack_clr(ack_vec), .q(gpp_q));

   // masks and command register
   logic [WORD_W-1:0] m0_lo, m0_hi, m_gpp;
   logic              m1_db;

   cirq_mask_bank #(.W(WORD_W), .DOORBELL_BIT(DOORBELL_BIT), .M0HI_RESET(SUM_BITS)) u_masks (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .m0_lo(m0_lo), .m0_hi(m0_hi), .m_gpp(m_gpp), .m1_db(m1_db));

   // cascade: pin groups fold into summary bits
   logic [WORD_W-1:0]     gpp_masked;
   logic [GPP_GROUPS-1:0] gpp_sum;
   logic [WORD_W-1:0]     hi_eff;

   assign gpp_masked = gpp_q & m_gpp;

   for (genvar g = 0; g < GPP_GROUPS; g++) begin : g_summary
      assign gpp_sum[g] = |gpp_masked[g*GRP_W +: GRP_W];
   end

   always_comb begin
      hi_eff = hi_q;
      hi_eff[CASCADE_LSB +: GPP_GROUPS] = gpp_sum;
   end

   // filtered, masked words and priority search
   logic [WORD_W-1:0] lo_sel, hi_sel;
   logic              lo_any, hi_any, gpp_any;
   logic [IDX_W-1:0]  lo_idx, hi_idx, gpp_idx;

   assign lo_sel = lo_q & LO_VALID & m0_lo;
   assign hi_sel = hi_eff & HI_VALID & m0_hi;

   cirq_msb_find #(.W(WORD_W)) u_find_lo  (.vec(lo_sel),     .any(lo_any),  .idx(lo_idx));
   cirq_msb_find #(.W(WORD_W)) u_find_hi  (.vec(hi_sel),     .any(hi_any),  .idx(hi_idx));
   cirq_msb_find #(.W(WORD_W)) u_find_gpp (.vec(gpp_masked), .any(gpp_any), .idx(gpp_idx));

   logic [ID_W-1:0] win_num;
   logic            gpp_hit;

   always_comb begin
      gpp_hit = 1'b0;
      win_num = BOGUS_ID;
      if (lo_any) begin
         win_num = ID_W'(lo_idx);
      end else if (hi_any) begin
         if (hi_idx >= CAS_LO && hi_idx <= CAS_HI && gpp_any) begin
            gpp_hit = 1'b1;
            win_num = GPP_BASE + ID_W'(gpp_idx);
         end else begin
            win_num = HI_BASE + ID_W'(hi_idx);
         end
      end
   end

   always_comb begin
      ack_vec = '0;
      if (id_req && gpp_hit)
         ack_vec[gpp_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_valid <= 1'b0;
         id_num   <= BOGUS_ID;
      end else begin
         id_valid <= id_req;
         if (id_req)
            id_num <= win_num;
      end
   end

   // processor lines
   assign cpu0_irq = lo_any | hi_any;
   assign cpu1_irq = lo_q[DOORBELL_BIT] & m1_db;

   // read path
   always_comb begin
      bus_rdata = '0;
      case (reg_addr_e'(bus_addr))
         RA_CAUSE_LO:  bus_rdata = lo_q;
         RA_CAUSE_HI:  bus_rdata = hi_eff;
         RA_CAUSE_GPP: bus_rdata = gpp_q;
         RA_MASK0_LO:  bus_rdata = m0_lo;
         RA_MASK0_HI:  bus_rdata = m0_hi;
         RA_MASK_GPP:  bus_rdata = m_gpp;
         RA_MASK1_LO:  bus_rdata[DOORBELL_BIT] = m1_db;
         default:      bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk #(
   parameter int unsigned     WORD_W       = 32,
   parameter int unsigned     DOORBELL_BIT = 28,
   parameter int unsigned     ID_W         = 8,
   parameter logic [ID_W-1:0] BOGUS_ID     = 8'hFE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [2:0]        bus_addr,
   input logic [WORD_W-1:0] bus_wdata,
   input logic              id_req,
   input logic              id_valid,
   input logic [ID_W-1:0]   id_num,
   input logic              cpu0_irq,
   input logic              cpu1_irq,
   input logic              lo_any,
   input logic              hi_any,
   input logic [WORD_W-1:0] lo_cause,
   input logic [WORD_W-1:0] gpp_cause
);
   localparam int unsigned     IDX_W    = $clog2(WORD_W);
   localparam logic [ID_W-1:0] GPP_BASE = ID_W'(2 * WORD_W);
   localparam logic [ID_W-1:0] GPP_END  = ID_W'(3 * WORD_W);

   a_r3_low_word_first: assert property (@(posedge clk) disable iff (!rst_n)
      id_req && lo_any |=> id_num < ID_W'(WORD_W));

   a_r5_bogus_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      id_req && !lo_any && !hi_any |=> id_valid && id_num == BOGUS_ID);

   a_r7_pin_acked: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid && id_num >= GPP_BASE && id_num < GPP_END
      |-> gpp_cause[IDX_W'(id_num - GPP_BASE)] == 1'b0);

   a_r8_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd0 |=> (lo_cause & ~$past(bus_wdata)) == '0);

   a_r10_cpu1_needs_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
      cpu1_irq |-> lo_cause[DOORBELL_BIT]);

   a_r12_line_means_winner: assert property (@(posedge clk) disable iff (!rst_n)
      cpu0_irq && id_req |=> id_num != BOGUS_ID);
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(
   .WORD_W(WORD_W), .DOORBELL_BIT(DOORBELL_BIT), .ID_W(ID_W), .BOGUS_ID(BOGUS_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .id_req(id_req), .id_valid(id_valid), .id_num(id_num),
   .cpu0_irq(cpu0_irq), .cpu1_irq(cpu1_irq), .lo_any(lo_any), .hi_any(hi_any),
   .lo_cause(lo_q), .gpp_cause(gpp_q)
);

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] src_lo, src_hi, src_gpp;
   logic        bus_wr;
   logic [2:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        id_req, id_valid;
   logic [7:0]  id_num;
   logic        cpu0_irq, cpu1_irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cascade_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi), .src_gpp(src_gpp),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .id_req(id_req), .id_valid(id_valid), .id_num(id_num),
      .cpu0_irq(cpu0_irq), .cpu1_irq(cpu1_irq));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic read_check(string req, logic [2:0] a, logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic irq_cmd(int num, bit en);
      bus_write(3'd7, {24'd0, en, 7'(num)});
   endtask

   // driver: queue the expected number, then pulse the request
   task automatic id_query(logic [7:0] exp, string req);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(req);
      id_req = 1'b1;
      @(negedge clk);
      id_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_causes();
      src_lo = '0; src_hi = '0; src_gpp = '0;
      bus_write(3'd0, 32'd0);
      bus_write(3'd1, 32'd0);
      bus_write(3'd2, 32'd0);
   endtask

   // monitor: pop and compare on every valid result
   always @(negedge clk) begin
      if (rst_n && id_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL id: actual 0x%0h expected none", id_num);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'd0, id_num}, {24'd0, e});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; src_lo = '0; src_hi = '0; src_gpp = '0;
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; id_req = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R11 reset state
      read_check("R11 mask0 lo", 3'd3, 32'h0);
      read_check("R11 mask0 hi", 3'd4, 32'h0f00_0000);
      read_check("R11 pin mask", 3'd5, 32'h0);
      read_check("R11 mask1",    3'd6, 32'h0);
      read_check("R11 cause lo", 3'd0, 32'h0);
      check("R11 cpu0 line", {31'd0, cpu0_irq}, 32'd0);
      check("R11 cpu1 line", {31'd0, cpu1_irq}, 32'd0);
      id_query(8'hFE, "R5 empty");

      // R13 / R1 / R12 single low source
      irq_cmd(5, 1'b1);
      read_check("R13 enable 5", 3'd3, 32'h0000_0020);
      src_lo = 32'h0000_0020;
      tick(1);
      check("R12 cpu0 line", {31'd0, cpu0_irq}, 32'd1);
      id_query(8'd5, "R1 low number");

      // R4 highest bit wins
      irq_cmd(17, 1'b1);
      src_lo = 32'h0002_0020;
      tick(1);
      id_query(8'd17, "R4 highest bit");

      // R2 filtered bits
      clear_causes();
      irq_cmd(0, 1'b1);
      irq_cmd(25, 1'b1);
      src_lo = 32'h0200_0001;
      tick(1);
      read_check("R2 cause latched", 3'd0, 32'h0200_0001);
      check("R2 cpu0 line", {31'd0, cpu0_irq}, 32'd0);
      id_query(8'hFE, "R2 filtered");

      // R3 low before high
      clear_causes();
      irq_cmd(3, 1'b1);
      irq_cmd(40, 1'b1);
      src_lo = 32'h0000_0008;
      src_hi = 32'h0000_0100;
      tick(1);
      id_query(8'd3, "R3 low first");
      src_lo = '0;
      bus_write(3'd0, 32'd0);
      tick(1);
      id_query(8'd40, "R3 then high");
      clear_causes();

      // R6 / R7 cascade through the pin word
      irq_cmd(74, 1'b1);
      read_check("R13 pin enable", 3'd5, 32'h0000_0400);
      src_gpp = 32'h0000_0400;
      tick(1);
      read_check("R6 summary 25", 3'd1, 32'h0200_0000);
      src_gpp = '0;
      id_query(8'd74, "R7 pin number");
      read_check("R7 pin cleared", 3'd2, 32'h0);
      src_gpp = 32'h0000_0008;
      tick(1);
      read_check("R6 masked pin", 3'd1, 32'h0);
      check("R6 cpu0 line", {31'd0, cpu0_irq}, 32'd0);
      clear_causes();

      // R8 / R9 write-zero clear and level re-set
      src_lo = 32'h0002_0020;
      tick(1);
      src_lo = '0;
      tick(1);
      bus_write(3'd0, ~32'h0002_0000);
      read_check("R8 partial clear", 3'd0, 32'h0000_0020);
      src_lo = 32'h0002_0000;
      bus_write(3'd0, 32'd0);
      read_check("R9 cleared", 3'd0, 32'h0);
      tick(1);
      read_check("R9 re-set", 3'd0, 32'h0002_0000);
      clear_causes();

      // R10 doorbell steering
      irq_cmd(28, 1'b1);
      read_check("R10 mask1", 3'd6, 32'h1000_0000);
      read_check("R10 mask0 lo unchanged", 3'd3, 32'h0202_0029);
      src_lo = 32'h1000_0000;
      tick(1);
      check("R10 cpu1 line", {31'd0, cpu1_irq}, 32'd1);
      check("R10 cpu0 quiet", {31'd0, cpu0_irq}, 32'd0);
      id_query(8'hFE, "R10 not for cpu0");
      irq_cmd(28, 1'b0);
      check("R10 cpu1 off", {31'd0, cpu1_irq}, 32'd0);
      read_check("R10 mask1 off", 3'd6, 32'h0);

      // R13 disable and out-of-range command
      irq_cmd(5, 1'b0);
      read_check("R13 disable 5", 3'd3, 32'h0202_0009);
      irq_cmd(100, 1'b1);
      read_check("R13 ignored lo", 3'd3, 32'h0202_0009);
      read_check("R13 ignored hi", 3'd4, 32'h0f00_0100);
      read_check("R13 ignored pin", 3'd5, 32'h0000_0400);

      // R7 ordering among pins
      irq_cmd(66, 1'b1);
      irq_cmd(94, 1'b1);
      src_gpp = 32'h4000_0004;
      tick(1);
      src_gpp = '0;
      id_query(8'd94, "R7 top pin");
      id_query(8'd66, "R7 next pin");
      id_query(8'hFE, "R5 drained");

      tick(3);
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL id: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule